// File: doc/BRIEF.md
# Self-Learning Harness Continuity Sequencer

This block sequences a continuity check of a multi-pin cable harness. Each step drives a walking pattern onto the harness pins, waits for the response vector read back from the far side, and then moves on. The pattern is a single high bit (walking ones) or a single low bit (walking zeros), selected at start. Every run covers all N pins, starting from pin 0.

A learn run is made on a harness known to be good, and the full response of each step is stored as the reference. A test run then applies the same steps to a harness under test and compares every response bit-for-bit against the stored vector. Because the reference is recorded rather than derived from a wiring list, any wiring works, including fan-out from one pin to many and pins tied together. On a test failure the block keeps the index of the first step that disagreed and the set of bits that differed there. It then finishes the remaining steps. Moving the bits to the physical pins and reading them back lies outside the block.

Top module: `harness_learn_seq`

## Requirements
- R1: With `invert`=0, step k (k = 0 .. N-1) drives `drive` with only bit k set. The step advances on each cycle where `busy` and `resp_valid` are both high.
- R2: With `invert`=1, step k drives the bitwise inverse of the R1 vector, so only bit k is low.
- R3: `drive` is all zeros while `busy` is low. `busy` rises the cycle after an accepted `start` and falls the cycle after the response of step N-1 is accepted. In that same cycle `done` rises, and it stays high until the next accepted `start`.
- R4: A learn run (`mode_test`=0) stores the response of every step as that step's reference. It ends with `pass`=1 and `fail`=0 and marks the reference as learned.
- R5: A test run (`mode_test`=1) compares the full N-bit response of each step with its reference. If all steps match, it ends with `pass`=1 and `fail`=0. `pass` and `fail` are never high together.
- R6: In a test run, `fail` rises the cycle after the first mismatching response is accepted and stays high until the next accepted `start`. The run still continues through step N-1.
- R7: `fail_step` holds the index of the first mismatching step. `fail_diff` holds the reference XOR the response at that step. Later mismatches in the same run leave both unchanged.
- R8: If a test run is started when no learn run has completed since reset, or since the last learn start, then the following cycle shows `done`=1, `fail`=1, `not_learned`=1 and `busy`=0, and no steps are driven.
- R9: `start` is ignored while `busy` is high: the current step and its drive vector are unchanged.
- R10: `resp_valid` while `busy` is low has no effect, and the stored reference is unchanged.
- R11: A new learn run replaces the whole previous reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (pulse) |
| mode_test | input | 1 | 0 = learn, 1 = test; sampled at start |
| invert | input | 1 | 0 = walking ones, 1 = walking zeros; sampled at start |
| drive | output | N | Pattern for the harness pins |
| resp | input | N | Response read from the harness pins |
| resp_valid | input | 1 | `resp` holds the response to the current step |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished |
| pass | output | 1 | Last run finished clean |
| fail | output | 1 | Mismatch seen, or test without reference |
| not_learned | output | 1 | Test refused for lack of a reference |
| fail_step | output | IW | Index of first mismatching step |
| fail_diff | output | N | Differing bits at first mismatch |

## Verification
The bench learns three wirings: straight-through, fan-out and two pins joined. It tests each learned wiring against every single-bit corruption of its connection matrix, in both polarities, and computes the expected first failing step and its difference mask from a model of the harness. A design that latched the last mismatch instead of the first, or stopped the run at the first mismatch, would report the wrong step or drop `busy` early. The bench also starts a test before any learn run (R8), pulses `start` in the middle of a run (R9), which a design that restarts would show as drive falling back to step 0, and pulses `resp_valid` while idle (R10), which would corrupt the reference and make a later clean test fail.

// File: rtl/harness_learn_seq.sv
module harness_learn_seq #(
  parameter int N = 8,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          mode_test,
  input  logic          invert,
  output logic [N-1:0]  drive,
  input  logic [N-1:0]  resp,
  input  logic          resp_valid,
  output logic          busy,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          not_learned,
  output logic [IW-1:0] fail_step,
  output logic [N-1:0]  fail_diff
);

  logic [N-1:0]  ref_mem [N];
  logic [IW-1:0] step;
  logic          mode_q, inv_q, learned;

  wire          last  = (step == IW'(N - 1));
  wire [N-1:0]  walk  = N'(1) << step;
  wire [N-1:0]  diff  = ref_mem[step] ^ resp;
  wire          go    = start && !busy;
  wire          take  = busy && resp_valid;

  assign drive = busy ? (inv_q ? ~walk : walk) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) ref_mem[i] <= '0;
      step        <= '0;
      mode_q      <= 1'b0;
      inv_q       <= 1'b0;
      learned     <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      pass        <= 1'b0;
      fail        <= 1'b0;
      not_learned <= 1'b0;
      fail_step   <= '0;
      fail_diff   <= '0;
    end else if (go) begin
      step        <= '0;
      mode_q      <= mode_test;
      inv_q       <= invert;
      pass        <= 1'b0;
      fail_step   <= '0;
      fail_diff   <= '0;
      if (mode_test && !learned) begin
        done        <= 1'b1;
        fail        <= 1'b1;
        not_learned <= 1'b1;
      end else begin
        busy        <= 1'b1;
        done        <= 1'b0;
        fail        <= 1'b0;
        not_learned <= 1'b0;
        if (!mode_test) learned <= 1'b0;
      end
    end else if (take) begin
      if (!mode_q) begin
        ref_mem[step] <= resp;
      end else if (diff != '0 && !fail) begin
        fail      <= 1'b1;
        fail_step <= step;
        fail_diff <= diff;
      end
      if (last) begin
        busy <= 1'b0;
        done <= 1'b1;
        if (!mode_q) begin
          learned <= 1'b1;
          pass    <= 1'b1;
        end else begin
          pass <= !fail && (diff == '0);
        end
      end else begin
        step <= step + 1'b1;
      end
    end
  end

endmodule

// File: rtl/harness_learn_seq_chk.sv
module harness_learn_seq_chk #(
  parameter int N = 8,
  parameter int IW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          resp_valid,
  input logic          inv,
  input logic [N-1:0]  drive,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          not_learned,
  input logic [IW-1:0] fail_step,
  input logic [N-1:0]  fail_diff
);

  AST_WALK_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !inv |-> $countones(drive) == 1); // R1
  AST_WALK_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
    busy && inv |-> $countones(~drive) == 1); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> drive == '0); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R3
  AST_PASS_FAIL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail)); // R5
  AST_FAIL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !(start && !busy) |=> fail); // R6
  AST_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    fail && !(start && !busy) |=> $stable(fail_step) && $stable(fail_diff)); // R7
  AST_NOT_LEARNED: assert property (@(posedge clk) disable iff (!rst_n)
    not_learned |-> fail && done && !busy); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start && !resp_valid |=> busy && $stable(drive)); // R9
  AST_IDLE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !start && resp_valid |=> !busy && $stable(done) && $stable(pass)); // R10

endmodule

bind harness_learn_seq harness_learn_seq_chk #(.N(N), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .resp_valid(resp_valid), .inv(inv_q),
  .drive(drive), .busy(busy), .done(done), .pass(pass), .fail(fail),
  .not_learned(not_learned), .fail_step(fail_step), .fail_diff(fail_diff)
);

// File: tb/tb_harness_learn_seq.sv
`timescale 1ns/1ps
module tb_harness_learn_seq;
  localparam int N  = 4;
  localparam int IW = 2;
  localparam int CW = N * N;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, mode_test = 1'b0, invert = 1'b0;
  logic [N-1:0] drive, resp = '0, fail_diff;
  logic resp_valid = 1'b0, busy, done, pass, fail, not_learned;
  logic [IW-1:0] fail_step;
  int checks = 0, errs = 0;

  always #2.5 clk = ~clk;

  harness_learn_seq #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_test(mode_test), .invert(invert),
    .drive(drive), .resp(resp), .resp_valid(resp_valid), .busy(busy), .done(done),
    .pass(pass), .fail(fail), .not_learned(not_learned), .fail_step(fail_step),
    .fail_diff(fail_diff)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] walk(int k, bit pol);
    logic [N-1:0] w = '0;
    w[k] = 1'b1;
    return pol ? ~w : w;
  endfunction

  function automatic logic [N-1:0] model(logic [N-1:0] d, logic [CW-1:0] c);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) if (d[i]) r |= c[i*N +: N];
    return r;
  endfunction

  task automatic pulse_start(bit tm, bit pol);
    mode_test = tm; invert = pol; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run(bit tm, bit pol, logic [CW-1:0] cab, logic [CW-1:0] gold);
    int first = -1;
    logic [N-1:0] fdiff = '0;
    pulse_start(tm, pol);
    for (int k = 0; k < N; k++) begin
      if (k == 1) begin
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R9", "drive after start while busy", drive, walk(1, pol));
      end
      chk(pol ? "R2" : "R1", "drive", drive, walk(k, pol));
      resp = model(walk(k, pol), cab);
      if (tm && first < 0 && resp != model(walk(k, pol), gold)) begin
        first = k;
        fdiff = resp ^ model(walk(k, pol), gold);
      end
      resp_valid = 1'b1;
      @(negedge clk);
      resp_valid = 1'b0;
      if (tm) chk("R6", "fail during run", fail, first >= 0);
      if (k < N - 1) chk("R6", "busy continues", busy, 1);
    end
    chk("R3", "busy end", busy, 0);
    chk("R3", "done end", done, 1);
    chk("R3", "idle drive", drive, 0);
    chk(tm ? "R5" : "R4", "pass", pass, first < 0);
    chk(tm ? "R5" : "R4", "fail", fail, first >= 0);
    chk("R8", "not_learned low", not_learned, 0);
    if (first >= 0) begin
      chk("R7", "fail_step", fail_step, first);
      chk("R7", "fail_diff", fail_diff, fdiff);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end

  initial begin
    logic [CW-1:0] ident, fan, joined;
    logic [CW-1:0] cabs [3];
    ident = '0;
    for (int i = 0; i < N; i++) ident[i*N + i] = 1'b1;
    fan = ident;    fan[0*N + 2] = 1'b1;
    joined = ident; joined[1*N + 3] = 1'b1; joined[3*N + 1] = 1'b1;
    cabs[0] = ident; cabs[1] = fan; cabs[2] = joined;

    repeat (3) @(negedge clk);
    chk("R3", "reset busy", busy, 0);
    chk("R3", "reset done", done, 0);
    chk("R3", "reset drive", drive, 0);
    chk("R5", "reset pass", pass, 0);
    chk("R6", "reset fail", fail, 0);
    rst_n = 1'b1;
    @(negedge clk);

    pulse_start(1'b1, 1'b0);
    chk("R8", "done", done, 1);
    chk("R8", "fail", fail, 1);
    chk("R8", "not_learned", not_learned, 1);
    chk("R8", "busy", busy, 0);
    chk("R8", "drive", drive, 0);

    for (int p = 0; p < 2; p++) begin
      for (int g = 0; g < 3; g++) begin
        run(1'b0, p[0], cabs[g], cabs[g]);
        resp = ~cabs[g][N-1:0];
        resp_valid = 1'b1;
        @(negedge clk);
        resp_valid = 1'b0;
        chk("R10", "idle resp_valid busy", busy, 0);
        run(1'b1, p[0], cabs[g], cabs[g]);
        for (int b = 0; b < CW; b++) run(1'b1, p[0], cabs[g] ^ (CW'(1) << b), cabs[g]);
      end
      run(1'b0, p[0], fan, fan);
      run(1'b1, p[0], ident, fan);
      chk("R11", "old reference replaced", fail, 1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, errs);
    $finish;
  end
endmodule